// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block runs a successive-approximation converter core across a set of input channels, one conversion at a time. Software picks the channels with an enable mask and starts a scan. The mask is captured when the scan begins. The sequencer then works through the captured channels from the lowest number to the highest, and stores each result in that channel's own result register. When the last captured channel has finished, it raises one interrupt pulse.

A scan can be started in two ways. Software can set the run bit. Or, in trigger mode, software selects one of several external trigger inputs and arms the block; the next rising edge on the selected input then sets the run bit. In both cases the scan does not begin until the clock-ready input reports a stable conversion clock. Until then the request waits with the run bit still set.

The converter core sits behind a small handshake. The sequencer gives a one-cycle start pulse, holds the channel index steady, and waits for a done pulse that comes with the result data.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, the control word (address 0), mask (address 1), flag (address 2) and every result register read as zero, and `irq_o` and `conv_start_o` are low.
- R2: Setting control bit 0 (the run bit) starts a scan when the clock-ready input is high. Enabled channels are converted in ascending order, starting at the lowest enabled one. Each conversion opens with a one-cycle `conv_start_o` pulse, and `conv_chan_o` holds steady until `conv_done_i` arrives.
- R3: The data that comes with `conv_done_i` for channel c is stored in the result register at address N_CH+c (low RES_W bits). Registers of channels that are not converted keep their values.
- R4: `irq_o` pulses high for exactly one cycle, only after the highest captured channel has completed. In that same cycle, bit 0 of the flag register is set and the run bit clears.
- R5: The enable mask (address 1, bit c enables channel c) is captured when the scan starts. Writing the mask during a scan does not change which channels that scan converts.
- R6: Control bit 1 selects trigger mode, bits 5:4 select which trigger input is used, and bit 2 arms the trigger. A rising edge on the selected trigger input, when trigger mode is selected and armed and no scan is active, sets the run bit and starts a scan. Edges on other trigger inputs, and edges while the trigger is not armed, do nothing. The arm bit stays set after the scan completes.
- R7: A start request made while `clk_ready_i` is low leaves the run bit set and starts no conversion. The scan begins once `clk_ready_i` goes high.
- R8: Starting a scan with an all-zero mask performs no conversion, clears the run bit, and raises no interrupt and no flag.
- R9: While a scan is active, run-bit writes and trigger edges are ignored. No further scan follows the one in progress.
- R10: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | REG_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | REG_W | Register read data (combinational) |
| trig_i | input | N_TRIG | External trigger inputs |
| clk_ready_i | input | 1 | Conversion clock is stable |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| conv_chan_o | output | CH_W | Channel under conversion |
| conv_done_i | input | 1 | Conversion finished pulse |
| conv_data_i | input | RES_W | Conversion result, valid with done |
| irq_o | output | 1 | Scan-complete interrupt pulse |

## Verification
The hardest case to reach from the ports is a request that arrives in the middle of a scan: a mask rewrite, a second run write, or a trigger edge, all landing after the captured set is already being walked. The bench's converter model logs every start it sees. The scan tasks wait for the first logged start, then issue those writes and trigger pulses while later conversions are still pending. Afterwards the bench checks the logged channel order, the result registers of channels that were not in the captured mask, and that no extra conversion or interrupt follows.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_state_e;

  // register addresses below the result window
  localparam int A_CTRL = 0;
  localparam int A_MASK = 1;
  localparam int A_FLAG = 2;

  // control word bit positions
  localparam int B_RUN  = 0;
  localparam int B_MODE = 1;
  localparam int B_ARM  = 2;
  localparam int B_SEL  = 4;

endpackage

// File: rtl/adc_scan_pick.sv
// Lowest set bit finder.
module adc_scan_pick #(
  parameter int N    = 8,
  parameter int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    vec_i,
  output logic [IDXW-1:0] idx_o,
  output logic            hit_o
);

  always_comb begin
    idx_o = '0;
    hit_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o = IDXW'(i);
        hit_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_scan_trig.sv
// Selected trigger input rising-edge detector.
module adc_scan_trig #(
  parameter int N_TRIG = 4,
  parameter int SEL_W  = $clog2(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              en_i,
  output logic              evt_o
);

  logic [N_TRIG-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= trig_i;
  end

  assign evt_o = en_i && trig_i[sel_i] && !prev_q[sel_i];

endmodule

// File: rtl/adc_scan_results.sv
// Per-channel result bank.
module adc_scan_results #(
  parameter int N_CH  = 8,
  parameter int RES_W = 12,
  parameter int CH_W  = $clog2(N_CH)
) (
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CH_W-1:0]  wch_i,
  input  logic [RES_W-1:0] wdata_i,
  input  logic [CH_W-1:0]  rch_i,
  output logic [RES_W-1:0] rdata_o
);

  logic [N_CH-1:0][RES_W-1:0] bank;

  for (genvar g = 0; g < N_CH; g++) begin : g_slot
    logic             slot_en;
    logic [RES_W-1:0] slot_q;

    assign slot_en = we_i && (wch_i == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= wdata_i;
    end

    assign bank[g] = slot_q;
  end

  assign rdata_o = bank[rch_i];

endmodule

// File: rtl/adc_scan_fsm.sv
// Channel walk and converter handshake.
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            go_i,
  input  logic [N_CH-1:0] mask_i,
  output logic            busy_o,
  output logic            empty_o,
  output logic            end_o,
  output logic [N_CH-1:0] mask_lat_o,
  output logic            conv_start_o,
  output logic [CH_W-1:0] conv_chan_o,
  input  logic            conv_done_i,
  output logic            res_we_o
);

  seq_state_e      state_q, state_d;
  logic [CH_W-1:0] cur_q, cur_d;
  logic            cur_en;
  logic [N_CH-1:0] lat_q;
  logic            lat_en;
  logic [N_CH-1:0] above;
  logic [CH_W-1:0] first_idx, nxt_idx;
  logic            first_hit, nxt_hit;

  adc_scan_pick #(.N(N_CH), .IDXW(CH_W)) u_first (
    .vec_i(mask_i), .idx_o(first_idx), .hit_o(first_hit)
  );

  always_comb begin
    for (int i = 0; i < N_CH; i++) begin
      above[i] = lat_q[i] && (i > int'(cur_q));
    end
  end

  adc_scan_pick #(.N(N_CH), .IDXW(CH_W)) u_next (
    .vec_i(above), .idx_o(nxt_idx), .hit_o(nxt_hit)
  );

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    cur_en   = 1'b0;
    lat_en   = 1'b0;
    empty_o  = 1'b0;
    end_o    = 1'b0;
    res_we_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          if (!first_hit) begin
            empty_o = 1'b1;
          end else begin
            state_d = ST_ISSUE;
            lat_en  = 1'b1;
            cur_d   = first_idx;
            cur_en  = 1'b1;
          end
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (conv_done_i) begin
          res_we_o = 1'b1;
          if (nxt_hit) begin
            cur_d   = nxt_idx;
            cur_en  = 1'b1;
            state_d = ST_ISSUE;
          end else begin
            end_o   = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= mask_i;
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign conv_start_o = (state_q == ST_ISSUE);
  assign conv_chan_o  = cur_q;
  assign mask_lat_o   = lat_q;

endmodule

// File: rtl/adc_scan_ctrl.sv
// Scan sequencer top: register file, start logic, interrupt.
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter  int N_CH   = 8,
  parameter  int RES_W  = 12,
  parameter  int N_TRIG = 4,
  parameter  int REG_W  = 16,
  localparam int CH_W   = $clog2(N_CH),
  localparam int SEL_W  = $clog2(N_TRIG),
  localparam int ADDR_W = $clog2(2 * N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [REG_W-1:0]  rd_data_o,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              clk_ready_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_data_i,
  output logic              irq_o
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync <= 2'b00;
    else         rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n = rst_sync[1];

  logic             run_q, run_d;
  logic             mode_q, arm_q;
  logic [SEL_W-1:0] sel_q;
  logic [N_CH-1:0]  mask_q;
  logic             flag_q, flag_d;
  logic             irq_q;
  logic             ctrl_wr, mask_wr, flag_wr;
  logic             busy, scan_empty, scan_end, res_we, trig_evt;
  logic [N_CH-1:0]  mask_lat;
  logic [RES_W-1:0] res_rd;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_CTRL));
  assign mask_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_MASK));
  assign flag_wr = wr_en_i && (wr_addr_i == ADDR_W'(A_FLAG));

  adc_scan_trig #(.N_TRIG(N_TRIG), .SEL_W(SEL_W)) u_trig (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .trig_i(trig_i),
    .sel_i (sel_q),
    .en_i  (mode_q && arm_q),
    .evt_o (trig_evt)
  );

  adc_scan_fsm #(.N_CH(N_CH), .CH_W(CH_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .go_i        (run_q && clk_ready_i),
    .mask_i      (mask_q),
    .busy_o      (busy),
    .empty_o     (scan_empty),
    .end_o       (scan_end),
    .mask_lat_o  (mask_lat),
    .conv_start_o(conv_start_o),
    .conv_chan_o (conv_chan_o),
    .conv_done_i (conv_done_i),
    .res_we_o    (res_we)
  );

  adc_scan_results #(.N_CH(N_CH), .RES_W(RES_W), .CH_W(CH_W)) u_res (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .we_i   (res_we),
    .wch_i  (conv_chan_o),
    .wdata_i(conv_data_i),
    .rch_i  (rd_addr_i[CH_W-1:0]),
    .rdata_o(res_rd)
  );

  // next-state for the run bit and the sticky flag
  always_comb begin
    run_d = run_q;
    if (scan_end || scan_empty) begin
      run_d = 1'b0;
    end else if (!busy && ((ctrl_wr && wr_data_i[B_RUN]) || trig_evt)) begin
      run_d = 1'b1;
    end
    flag_d = flag_q;
    if (flag_wr && wr_data_i[0]) flag_d = 1'b0;
    if (scan_end)                flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      flag_q <= flag_d;
      irq_q  <= scan_end;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      arm_q  <= 1'b0;
      sel_q  <= '0;
    end else if (ctrl_wr) begin
      mode_q <= wr_data_i[B_MODE];
      arm_q  <= wr_data_i[B_ARM];
      sel_q  <= wr_data_i[B_SEL +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wr_data_i[N_CH-1:0];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i >= ADDR_W'(N_CH)) begin
      rd_data_o[RES_W-1:0] = res_rd;
    end else if (rd_addr_i == ADDR_W'(A_CTRL)) begin
      rd_data_o[B_RUN]            = run_q;
      rd_data_o[B_MODE]           = mode_q;
      rd_data_o[B_ARM]            = arm_q;
      rd_data_o[B_SEL +: SEL_W]   = sel_q;
    end else if (rd_addr_i == ADDR_W'(A_MASK)) begin
      rd_data_o[N_CH-1:0] = mask_q;
    end else if (rd_addr_i == ADDR_W'(A_FLAG)) begin
      rd_data_o[0] = flag_q;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/adc_scan_ctrl_chk.sv
module adc_scan_ctrl_chk #(
  parameter int N_CH = 8,
  parameter int CH_W = $clog2(N_CH)
) (
  input logic            clk_i,
  input logic            rst_n,
  input logic            conv_start,
  input logic [CH_W-1:0] conv_chan,
  input logic            conv_done,
  input logic            busy,
  input logic [N_CH-1:0] mask_lat,
  input logic            irq,
  input logic            flag,
  input logic            run
);

  // R2
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R2
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(busy) && busy && !$past(conv_done)) |-> $stable(conv_chan));

  // R5
  start_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    conv_start |-> mask_lat[conv_chan]);

  // R4
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |=> !irq);

  // R4
  irq_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> (flag && !run));

  // R4
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq |-> !busy);

endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.N_CH(N_CH), .CH_W(CH_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n),
  .conv_start(conv_start_o),
  .conv_chan (conv_chan_o),
  .conv_done (conv_done_i),
  .busy      (busy),
  .mask_lat  (mask_lat),
  .irq       (irq_o),
  .flag      (flag_q),
  .run       (run_q)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 8;
  localparam int RES_W  = 12;
  localparam int N_TRIG = 4;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int DLY    = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [REG_W-1:0]  wr_data, rd_data;
  logic [N_TRIG-1:0] trig;
  logic              clk_ready;
  logic              conv_start, conv_done, irq;
  logic [2:0]        conv_chan;
  logic [RES_W-1:0]  conv_data;

  int total = 0;
  int bad   = 0;
  int seed  = 0;
  int log_ch [64];
  int log_n     = 0;
  int chan_bad  = 0;
  int irq_cnt   = 0;
  int irq_long  = 0;
  int irq_at    = 0;
  bit irq_prev  = 1'b0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  adc_scan_ctrl #(.N_CH(N_CH), .RES_W(RES_W), .N_TRIG(N_TRIG), .REG_W(REG_W)) u_adc_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .trig_i(trig), .clk_ready_i(clk_ready),
    .conv_start_o(conv_start), .conv_chan_o(conv_chan),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .irq_o(irq)
  );

  function automatic int expect_res(int s, int ch);
    return (s + ch * 37) & 12'hFFF;
  endfunction

  // converter model
  initial begin
    conv_done = 1'b0;
    conv_data = '0;
    forever begin
      if (conv_start === 1'b1) begin
        int ch;
        ch = int'(conv_chan);
        if (log_n < 64) log_ch[log_n] = ch;
        log_n++;
        for (int k = 0; k < DLY; k++) begin
          @(negedge clk);
          if (int'(conv_chan) != ch) chan_bad++;
        end
        conv_data = RES_W'(expect_res(seed, ch));
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // interrupt monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irq === 1'b1) begin
        irq_cnt++;
        irq_at = log_n;
        if (irq_prev) irq_long++;
      end
      irq_prev = (irq === 1'b1);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = REG_W'(d);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = ADDR_W'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_irq(input int target);
    int n = 0;
    while (irq_cnt < target && n < 500) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_log(input int target);
    int n = 0;
    while (log_n < target && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_trig(input int idx);
    @(negedge clk);
    trig[idx] = 1'b1;
    repeat (2) @(negedge clk);
    trig[idx] = 1'b0;
  endtask

  task automatic t_reset;
    int v;
    rd(0, v);  chk("R1", "ctrl after reset", v, 0);
    rd(1, v);  chk("R1", "mask after reset", v, 0);
    rd(2, v);  chk("R1", "flag after reset", v, 0);
    rd(11, v); chk("R1", "result ch3 after reset", v, 0);
    chk("R1", "irq after reset", int'(irq), 0);
    chk("R1", "conv_start after reset", int'(conv_start), 0);
  endtask

  task automatic t_normal;
    int v, base, ic;
    seed = 100;
    base = log_n;
    ic   = irq_cnt;
    wr(1, 8'b1010_0110);
    wr(0, 1);
    wait_irq(ic + 1);
    chk("R2", "conversions in scan", log_n - base, 4);
    chk("R2", "order 1st", log_ch[base], 1);
    chk("R2", "order 2nd", log_ch[base + 1], 2);
    chk("R2", "order 3rd", log_ch[base + 2], 5);
    chk("R2", "order 4th", log_ch[base + 3], 7);
    chk("R2", "channel held while converting", chan_bad, 0);
    for (int c = 0; c < N_CH; c++) begin
      rd(N_CH + c, v);
      if (c == 1 || c == 2 || c == 5 || c == 7) chk("R3", "stored result", v, expect_res(seed, c));
      else chk("R3", "untouched result", v, 0);
    end
    chk("R4", "one interrupt", irq_cnt - ic, 1);
    chk("R4", "interrupt after last channel", irq_at - base, 4);
    chk("R4", "interrupt one cycle", irq_long, 0);
    rd(0, v); chk("R4", "run cleared", v & 1, 0);
    rd(2, v); chk("R4", "flag set", v, 1);
  endtask

  task automatic t_flag;
    int v;
    wr(2, 0);
    rd(2, v); chk("R10", "flag after writing 0", v, 1);
    wr(2, 1);
    rd(2, v); chk("R10", "flag after writing 1", v, 0);
  endtask

  task automatic t_zero_mask;
    int v, base, ic;
    base = log_n;
    ic   = irq_cnt;
    wr(1, 0);
    wr(0, 1);
    repeat (20) @(negedge clk);
    chk("R8", "no conversion", log_n - base, 0);
    chk("R8", "no interrupt", irq_cnt - ic, 0);
    rd(0, v); chk("R8", "run cleared", v & 1, 0);
    rd(2, v); chk("R8", "flag stays clear", v, 0);
  endtask

  task automatic t_mask_latch;
    int v, base, ic;
    seed = 900;
    base = log_n;
    ic   = irq_cnt;
    wr(1, 8'b0000_0101);
    wr(0, 1);
    wait_log(base + 1);
    wr(1, 8'hFF);
    wr(0, 1);
    wait_irq(ic + 1);
    repeat (40) @(negedge clk);
    chk("R5", "conversions with mask rewritten", log_n - base, 2);
    chk("R5", "first channel", log_ch[base], 0);
    chk("R5", "second channel", log_ch[base + 1], 2);
    rd(N_CH + 1, v); chk("R5", "ch1 kept earlier result", v, expect_res(100, 1));
    rd(N_CH + 2, v); chk("R3", "ch2 new result", v, expect_res(seed, 2));
    chk("R9", "run write in scan ignored", irq_cnt - ic, 1);
    rd(0, v); chk("R9", "run not left pending", v & 1, 0);
    rd(1, v); chk("R5", "mask write kept for later", v, 8'hFF);
  endtask

  task automatic t_clk_ready;
    int v, base, ic;
    seed = 300;
    base = log_n;
    ic   = irq_cnt;
    clk_ready = 1'b0;
    wr(1, 8'h80);
    wr(0, 1);
    repeat (30) @(negedge clk);
    chk("R7", "no conversion without clock ready", log_n - base, 0);
    rd(0, v); chk("R7", "run pending", v & 1, 1);
    clk_ready = 1'b1;
    wait_irq(ic + 1);
    chk("R7", "conversions after ready", log_n - base, 1);
    chk("R7", "channel after ready", log_ch[base], 7);
    rd(N_CH + 7, v); chk("R3", "ch7 result", v, expect_res(seed, 7));
  endtask

  task automatic t_trigger;
    int v, base, ic;
    seed = 2000;
    wr(1, 8'b0000_1001);
    wr(0, 32'h22);
    base = log_n;
    ic   = irq_cnt;
    pulse_trig(2);
    repeat (20) @(negedge clk);
    chk("R6", "unarmed trigger ignored", log_n - base, 0);
    wr(0, 32'h26);
    pulse_trig(1);
    repeat (20) @(negedge clk);
    chk("R6", "other input ignored", log_n - base, 0);
    pulse_trig(2);
    wait_log(base + 1);
    pulse_trig(2);
    wait_irq(ic + 1);
    repeat (30) @(negedge clk);
    chk("R6", "trigger scan conversions", log_n - base, 2);
    chk("R6", "trigger scan order", log_ch[base + 1], 3);
    chk("R9", "trigger in scan ignored", irq_cnt - ic, 1);
    rd(0, v); chk("R6", "still armed", (v >> 2) & 1, 1);
    rd(N_CH + 3, v); chk("R3", "ch3 result", v, expect_res(seed, 3));
    pulse_trig(2);
    wait_irq(ic + 2);
    chk("R6", "rearmed second scan", log_n - base, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    wr_en     = 1'b0;
    wr_addr   = '0;
    wr_data   = '0;
    rd_addr   = '0;
    trig      = '0;
    clk_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_normal();
    t_flag();
    t_zero_mask();
    t_mask_latch();
    t_clk_ready();
    t_trigger();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule